// File: doc/BRIEF.md
# Switchable-Mode Fourth-Order Sinc Decimator

This block turns the single-bit output of a delta-sigma modulator into signed multi-bit words at a rate reduced by a power-of-two ratio R. It is a cascade of four wrapping accumulators running at the sample rate, followed by four differencing stages that run once every R samples. The result is a sinc-to-the-fourth response.

Each conversion begins with a start strobe, and the filter is cleared at that strobe. The mode input, captured at the start strobe, picks one of two behaviours. In one-shot mode the block emits a single word once 4R samples have been taken in, clears itself and waits for the next strobe. In free-running mode it emits a first word after the same 4R samples and then one word every R samples, and its state is never cleared until a new strobe arrives. Samples count only in cycles where the sample enable is high.

Top module: `sinc4_decim`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data` is 0. Samples that arrive while no conversion has been started cause no output.
- R2: A sample bit of 1 counts as +1 and a bit of 0 counts as -1. The full-precision word produced at sample n of a conversion equals the sum over j of h[j]·x[n-j]. Here h is the coefficient list of (1+z^-1+…+z^-(R-1))^4, which has 4R-3 taps, and samples from before the conversion count as 0.
- R3: One-shot mode (`mode`=1 at start): exactly one word is produced, on the 4R-th accepted sample. The filter is then cleared, and further samples give no output until the next start.
- R4: Free-running mode (`mode`=0 at start): words are produced on accepted samples 4R, 5R, 6R and so on, with no clearing in between.
- R5: `mode` is sampled only in the cycle of `start`. A change of `mode` during a conversion has no effect on it.
- R6: A `start` during a conversion abandons that conversion, with no word from it. This holds even when the `start` falls on the sample that would have completed it. A sample accepted in the `start` cycle is sample 1 of the new conversion.
- R7: `bit_in` is ignored, and no sample is counted, in cycles where `bit_en` is 0.
- R8: The full-precision word is 4·log2(R)+2 bits wide. When `OUT_W` is smaller, `out_data` is that word shifted right arithmetically by the difference (floor). Otherwise `out_data` is the word sign-extended.
- R9: `out_valid` is high for one cycle per word, in the cycle after the clock edge that accepted the completing sample.
- R10: Internal sums wrap modulo 2^width. A long free-running conversion of constant input still yields R^4 (for all ones) after scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Sample enable; one modulator sample per high cycle |
| bit_in | input | 1 | Modulator bit |
| mode | input | 1 | 1 = one-shot, 0 = free-running; captured at `start` |
| start | input | 1 | Clears the filter and begins a conversion |
| out_valid | output | 1 | One-cycle strobe marking a new word |
| out_data | output | OUT_W | Signed decimated word |

## Verification
The conflict of interest is a `start` that arrives in the same cycle as the sample that would complete a word. In that cycle the clearing of the filter and the emission of an output compete. The bench provokes this in both modes: it starts a conversion, feeds samples up to one short of the completing count, and then presents the completing sample together with a new `start`. It judges the result by the absence of any word in the following cycle, and by the next word matching a reference convolution that treats the colliding sample as the first of the new conversion.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    localparam int NUM_STAGES    = 4;
    localparam int SETTLE_BLOCKS = 4;
    localparam int BLK_W         = $clog2(SETTLE_BLOCKS);

    typedef enum logic {
        MODE_CONT   = 1'b0,
        MODE_SINGLE = 1'b1
    } conv_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // per-cycle control bundle from the sequencer to the datapath
    typedef struct packed {
        logic step;      // accept one sample into the integrators
        logic tick;      // decimation point: run the combs
        logic emit;      // this tick produces a settled word
        logic clr_pre;   // clear before the sample of this cycle
        logic clr_post;  // clear after the sample of this cycle
    } seq_ctrl_t;

    // full-precision accumulator width for ratio 2**log2r
    function automatic int acc_width(input int log2r);
        return NUM_STAGES * log2r + 2;
    endfunction

endpackage

// File: rtl/sinc4_sequencer.sv
module sinc4_sequencer
    import sinc4_pkg::*;
#(
    parameter int DECIM_LOG2 = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      start,
    input  logic      mode,
    output seq_ctrl_t ctrl,
    output logic      busy
);

    localparam logic [DECIM_LOG2-1:0] LAST_PHASE = {DECIM_LOG2{1'b1}};
    localparam logic [BLK_W-1:0]      LAST_BLOCK = BLK_W'(SETTLE_BLOCKS - 1);

    seq_state_e            state_q;
    conv_mode_e            mode_q;
    conv_mode_e            run_mode;
    logic [DECIM_LOG2-1:0] phase_q;
    logic [DECIM_LOG2-1:0] phase_base;
    logic [BLK_W-1:0]      blk_q;
    logic [BLK_W-1:0]      blk_base;
    logic                  running;
    logic                  step_c;
    logic                  tick_c;
    logic                  emit_c;
    logic                  post_c;

    always_comb begin
        running    = (state_q == SEQ_RUN) || start;
        phase_base = start ? '0 : phase_q;
        blk_base   = start ? '0 : blk_q;
        run_mode   = start ? conv_mode_e'(mode) : mode_q;
        step_c     = bit_en && running;
        tick_c     = step_c && (phase_base == LAST_PHASE);
        emit_c     = tick_c && (blk_base == LAST_BLOCK);
        post_c     = emit_c && (run_mode == MODE_SINGLE);
    end

    assign ctrl.step     = step_c;
    assign ctrl.tick     = tick_c;
    assign ctrl.emit     = emit_c;
    assign ctrl.clr_pre  = start;
    assign ctrl.clr_post = post_c;
    assign busy          = (state_q == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            mode_q  <= MODE_CONT;
            phase_q <= '0;
            blk_q   <= '0;
        end else if (post_c) begin
            state_q <= SEQ_IDLE;
            mode_q  <= run_mode;
            phase_q <= '0;
            blk_q   <= '0;
        end else begin
            if (start) begin
                state_q <= SEQ_RUN;
            end
            mode_q  <= run_mode;
            phase_q <= step_c ? phase_base + DECIM_LOG2'(1) : phase_base;
            blk_q   <= (tick_c && (blk_base != LAST_BLOCK)) ? blk_base + BLK_W'(1) : blk_base;
        end
    end

    // R3
    idle_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> (phase_q == '0 && blk_q == '0));

    // R3
    single_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (emit_c && run_mode == MODE_SINGLE) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/sinc4_integrators.sv
module sinc4_integrators
    import sinc4_pkg::*;
#(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clr_pre,
    input  logic         clr_post,
    input  logic         bit_in,
    output logic [W-1:0] last_sum
);

    logic [W-1:0] acc_q [NUM_STAGES];
    logic [W-1:0] sum_c [NUM_STAGES];
    logic [W-1:0] inc;

    // +1 for a one, -1 (all ones) for a zero; all sums wrap modulo 2**W
    assign inc = bit_in ? W'(1) : {W{1'b1}};

    always_comb begin
        logic [W-1:0] run;
        run = inc;
        for (int k = 0; k < NUM_STAGES; k++) begin
            run      = (clr_pre ? '0 : acc_q[k]) + run;
            sum_c[k] = run;
        end
    end

    assign last_sum = sum_c[NUM_STAGES-1];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (rst || clr_post) begin
                acc_q[k] <= '0;
            end else if (step) begin
                acc_q[k] <= sum_c[k];
            end else if (clr_pre) begin
                acc_q[k] <= '0;
            end
        end
    end

    // R3
    first_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_post |=> (acc_q[0] == '0 && acc_q[NUM_STAGES-1] == '0));

endmodule

// File: rtl/sinc4_combs.sv
module sinc4_combs
    import sinc4_pkg::*;
#(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr_pre,
    input  logic         clr_post,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] dly_q    [NUM_STAGES];
    logic [W-1:0] stage_in [NUM_STAGES];

    always_comb begin
        logic [W-1:0] run;
        run = din;
        for (int k = 0; k < NUM_STAGES; k++) begin
            stage_in[k] = run;
            run         = run - (clr_pre ? '0 : dly_q[k]);
        end
        dout = run;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (rst || clr_post) begin
                dly_q[k] <= '0;
            end else if (tick) begin
                dly_q[k] <= stage_in[k];
            end else if (clr_pre) begin
                dly_q[k] <= '0;
            end
        end
    end

    // R3
    comb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_post |=> (dly_q[0] == '0 && dly_q[NUM_STAGES-1] == '0));

endmodule

// File: rtl/sinc4_outstage.sv
module sinc4_outstage #(
    parameter int W     = 34,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             emit,
    input  logic [W-1:0]     full,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    logic [OUT_W-1:0] scaled;

    if (OUT_W > W) begin : g_extend
        assign scaled = {{(OUT_W - W){full[W-1]}}, full};
    end else if (OUT_W == W) begin : g_same
        assign scaled = full;
    end else begin : g_trunc
        assign scaled = full[W-1 -: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= scaled;
            end
        end
    end

endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter int DECIM_LOG2 = 8,
    parameter int OUT_W      = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             mode,
    input  logic             start,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    localparam int W = acc_width(DECIM_LOG2);

    seq_ctrl_t    ctrl;
    logic         busy;
    logic [W-1:0] integ_out;
    logic [W-1:0] comb_out;

    sinc4_sequencer #(.DECIM_LOG2(DECIM_LOG2)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .start  (start),
        .mode   (mode),
        .ctrl   (ctrl),
        .busy   (busy)
    );

    sinc4_integrators #(.W(W)) u_integ (
        .clk      (clk),
        .rst      (rst),
        .step     (ctrl.step),
        .clr_pre  (ctrl.clr_pre),
        .clr_post (ctrl.clr_post),
        .bit_in   (bit_in),
        .last_sum (integ_out)
    );

    sinc4_combs #(.W(W)) u_comb (
        .clk      (clk),
        .rst      (rst),
        .tick     (ctrl.tick),
        .clr_pre  (ctrl.clr_pre),
        .clr_post (ctrl.clr_post),
        .din      (integ_out),
        .dout     (comb_out)
    );

    sinc4_outstage #(.W(W), .OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (ctrl.emit),
        .full      (comb_out),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // independent sample-window tracker used only by the checks below
    logic [DECIM_LOG2-1:0] chk_phase;
    logic [2:0]            chk_blocks;
    logic                  chk_take;

    assign chk_take = bit_en && (busy || start);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_phase  <= '0;
            chk_blocks <= '0;
        end else if (start) begin
            chk_phase  <= chk_take ? DECIM_LOG2'(1) : '0;
            chk_blocks <= '0;
        end else if (chk_take) begin
            chk_phase <= chk_phase + DECIM_LOG2'(1);
            if (chk_phase == {DECIM_LOG2{1'b1}} && chk_blocks != 3'd4) begin
                chk_blocks <= chk_blocks + 3'd1;
            end
        end
    end

    // R4
    window_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (chk_phase == '0 && chk_blocks == 3'd4));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: tb/sinc4_decim_bench.sv
module sinc4_decim_bench;

    localparam int CLK_P  = 10;
    localparam int LOG2R  = 3;
    localparam int R      = 1 << LOG2R;
    localparam int OW     = 12;
    localparam int FULL_W = 4 * LOG2R + 2;
    localparam int SHIFT  = FULL_W - OW;
    localparam int HL     = 4 * R - 3;
    localparam int MAXN   = 1024;

    logic          clk = 1'b0;
    logic          rst;
    logic          bit_en;
    logic          bit_in;
    logic          mode;
    logic          start;
    logic          out_valid;
    logic [OW-1:0] out_data;

    sinc4_decim #(.DECIM_LOG2(LOG2R), .OUT_W(OW)) u_sinc4_decim (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .mode      (mode),
        .start     (start),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_P/2) clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R1";
    int    h [HL];
    bit    hist [MAXN];
    int    n_m;
    bit    active_m;
    bit    single_m;
    int    valid_seen;
    logic [15:0] lf = 16'hACE1;

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int ref_word(input int n);
        int s = 0;
        for (int j = 0; j < HL; j++) begin
            int k = n - j;
            if (k >= 1) s += h[j] * (hist[k] ? 1 : -1);
        end
        return s >>> SHIFT;
    endfunction

    function automatic bit lfsr_bit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    // one clock: drive at the falling edge, judge after the rising edge
    task automatic cyc(input bit en, input bit b, input bit st, input bit md);
        bit exp_v;
        @(negedge clk);
        bit_en = en; bit_in = b; start = st; mode = md;
        @(posedge clk);
        #1;
        if (st) begin
            active_m = 1; single_m = md; n_m = 0;
        end
        exp_v = 0;
        if (active_m && en) begin
            n_m++;
            hist[n_m] = b;
            if (n_m >= 4 * R && (n_m % R) == 0) exp_v = 1;
        end
        check({cur_req, " valid"}, int'(out_valid), int'(exp_v));
        if (exp_v) begin
            valid_seen++;
            check({cur_req, " data"}, int'($signed(out_data)), ref_word(n_m));
            if (single_m) active_m = 0;
        end
    endtask

    task automatic idle_cycle();
        cyc(0, 0, 0, mode);
    endtask

    task automatic t_reset_and_idle();
        cur_req = "R1";
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", int'(out_data), 0);
        for (int i = 0; i < 40; i++) cyc(1, lfsr_bit(), 0, 1);
        check("R1 idle data", int'(out_data), 0);
    endtask

    task automatic t_single_random();
        cur_req = "R2";
        valid_seen = 0;
        cyc(1, lfsr_bit(), 1, 1);
        for (int i = 1; i < 4 * R; i++) cyc(1, lfsr_bit(), 0, 1);
        cur_req = "R3";
        for (int i = 0; i < 3 * R; i++) cyc(1, lfsr_bit(), 0, 1);
        check("R3 one word", valid_seen, 1);
    endtask

    task automatic t_single_constant(input bit b);
        int want = b ? ((R * R * R * R) >>> SHIFT) : -((R * R * R * R) >>> SHIFT);
        cur_req = "R8";
        cyc(1, b, 1, 1);
        for (int i = 1; i < 4 * R; i++) cyc(1, b, 0, 1);
        check("R8 full scale", int'($signed(out_data)), want);
    endtask

    task automatic t_enable_gaps();
        cur_req = "R7";
        valid_seen = 0;
        cyc(0, 0, 1, 1);
        for (int i = 0; i < 4 * R; i++) begin
            cyc(1, lfsr_bit(), 0, 1);
            cyc(0, ~bit_in, 0, 1);
            if (i % 5 == 0) cyc(0, 1, 0, 1);
        end
        check("R7 one word", valid_seen, 1);
    endtask

    task automatic t_mode_latched();
        cur_req = "R5";
        valid_seen = 0;
        cyc(1, lfsr_bit(), 1, 1);
        for (int i = 1; i < 6 * R; i++) cyc(1, lfsr_bit(), 0, 0);
        check("R5 one word", valid_seen, 1);
    endtask

    task automatic t_continuous();
        cur_req = "R4";
        valid_seen = 0;
        cyc(1, lfsr_bit(), 1, 0);
        for (int i = 1; i < 25 * R; i++) cyc(1, lfsr_bit(), 0, 0);
        check("R4 word count", valid_seen, 22);
        cur_req = "R9";
        idle_cycle();
        idle_cycle();
    endtask

    task automatic t_wrap_long();
        cur_req = "R10";
        cyc(1, 1, 1, 0);
        for (int i = 1; i < 60 * R; i++) cyc(1, 1, 0, 0);
        check("R10 wrapped sum", int'($signed(out_data)), (R * R * R * R) >>> SHIFT);
    endtask

    task automatic t_collision(input bit md);
        cur_req = "R6";
        valid_seen = 0;
        cyc(1, lfsr_bit(), 1, md);
        for (int i = 1; i < 4 * R - 1; i++) cyc(1, lfsr_bit(), 0, md);
        cyc(1, lfsr_bit(), 1, md);
        check("R6 no word on collision", valid_seen, 0);
        for (int i = 1; i < 4 * R; i++) cyc(1, lfsr_bit(), 0, md);
        check("R6 new conversion word", valid_seen, 1);
        cyc(1, 0, 1, 1);
        for (int i = 1; i < 4 * R; i++) cyc(1, lfsr_bit(), 0, 1);
    endtask

    initial begin
        int cur [4 * R];
        int nxt [4 * R];
        int len;
        for (int i = 0; i < 4 * R; i++) cur[i] = 0;
        for (int i = 0; i < R; i++) cur[i] = 1;
        len = R;
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 4 * R; i++) nxt[i] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < R; j++) nxt[i + j] += cur[i];
            len = len + R - 1;
            for (int i = 0; i < 4 * R; i++) cur[i] = nxt[i];
        end
        for (int i = 0; i < HL; i++) h[i] = cur[i];

        active_m = 0; single_m = 0; n_m = 0; valid_seen = 0;
        rst = 1; bit_en = 0; bit_in = 0; mode = 0; start = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;

        t_reset_and_idle();
        t_single_random();
        t_single_constant(1'b1);
        t_single_constant(1'b0);
        t_enable_gaps();
        t_mode_latched();
        t_continuous();
        t_wrap_long();
        t_collision(1'b1);
        t_collision(1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule